// File: doc/BRIEF.md
# SPI Flash Single-Page Write-Back Cache

This block connects a byte-wide request port to a serial NOR flash that is reached through a byte-level SPI shift engine. It keeps a copy of one flash page in a local buffer, together with the number of that page and a flag that records unsaved changes. Byte reads and writes that fall in the buffered page are served locally without touching the flash. A request for another page first saves a modified buffer with a page-program command and then loads the requested page with a read command. Programming is left to finish in the background. Only when the next read or program command is due does the block poll the device status until the busy phase is over.

The last page of the device is set aside for configuration data and is reached with a separate request flag. A configuration write is saved to flash before the block answers. A flush strobe saves a modified buffer on demand. Requests that point outside the data region are refused and cause no SPI traffic. A caller that is about to rewrite a whole page can ask that the load be skipped.

Top module: `spi_page_cache`

## Requirements
- R1: After reset, req_ready is 1, spi_cs_n is 1, resp_valid is 0, and no page is held: the tag is all ones, one bit wider than a page number. The first access of any page loads it.
- R2: A read or write to the buffered page completes with no SPI traffic. A read returns the most recent byte written at that offset, or else the loaded flash byte.
- R3: An access to another page saves the buffer with one program command when it is dirty, then issues one read command for the new page. A clean buffer is replaced with only the read command.
- R4: A write with req_whole=1 to an unbuffered page issues no read command. It saves a dirty buffer, retags the buffer to the new page and merges the byte. Bytes not yet written keep their old buffer contents.
- R5: Every read (0x03) and program (0x02) command is the opcode followed by three address bytes, MSB first, equal to page << PAGE_BITS, so the low byte is 0x00. A program then carries all page bytes from offset 0 upward.
- R6: After a program command, the next read or program command is preceded by status commands (0x05, one returned byte). These repeat until bit 7 of the returned byte is 1, and no read or program is issued while the device is busy.
- R7: A flush_req taken while idle saves a dirty buffer with one program command and then pulses flush_ack for one cycle. A flush of a clean buffer pulses flush_ack with no SPI traffic.
- R8: With req_cfg=1, req_addr is an offset into the last device page. A configuration write loads that page if needed, merges the byte and programs the page before resp_valid. A configuration read is a normal cached read of that page.
- R9: A data access whose page number is all ones, or a configuration access whose address has nonzero page bits, is answered with resp_ok=0. It causes no SPI traffic and leaves the buffer, tag and dirty flag unchanged.
- R10: spi_cs_n falls at least GUARD cycles before the first byte of a command and rises at least GUARD cycles after its last byte. It stays high at least GUARD cycles between commands.
- R11: Only one request is in progress at a time. req_ready is 0 from the cycle after acceptance until the resp_valid or flush_ack pulse, and it is 1 in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = write byte, 0 = read byte |
| req_whole | input | 1 | Write is part of a whole-page rewrite; skip the load |
| req_cfg | input | 1 | Access the configuration page |
| req_addr | input | PNUM_W+PAGE_BITS | Byte address (offset when req_cfg) |
| req_wdata | input | 8 | Write byte |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_ok | output | 1 | 0 = request refused |
| resp_rdata | output | 8 | Read byte |
| flush_req | input | 1 | Flush strobe, sampled while idle with no request |
| flush_ack | output | 1 | One-cycle flush completion pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_go | output | 1 | Start one byte exchange on the shift engine |
| spi_txd | output | 8 | Byte to shift out |
| spi_done | input | 1 | Shift engine finished the byte exchange |
| spi_rxd | input | 8 | Byte shifted in |

## Verification
A stale tag or a lost dirty flag does not show up at once. It appears at the next page change, as a missing or extra program or read command, or as a wrong byte when that page is read back. The bench therefore counts commands per request and compares the complete flash image after a final flush. A wrong write-pending flag shows up at the next read or program command, which then reaches a busy device. Framing faults show at the first command as a nonzero low address byte, a short page program, or a guard interval shorter than GUARD.

// File: rtl/spi_page_cache.sv
module spi_page_cache #(
  parameter int PAGE_BITS = 8,
  parameter int PNUM_W = 8,
  parameter int GUARD = 2,
  parameter logic [7:0] OP_READ = 8'h03,
  parameter logic [7:0] OP_PROG = 8'h02,
  parameter logic [7:0] OP_STAT = 8'h05,
  parameter int RDY_BIT = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic                        req_whole,
  input  logic                        req_cfg,
  input  logic [PNUM_W+PAGE_BITS-1:0] req_addr,
  input  logic [7:0]                  req_wdata,
  output logic                        resp_valid,
  output logic                        resp_ok,
  output logic [7:0]                  resp_rdata,
  input  logic                        flush_req,
  output logic                        flush_ack,
  output logic                        spi_cs_n,
  output logic                        spi_go,
  output logic [7:0]                  spi_txd,
  input  logic                        spi_done,
  input  logic [7:0]                  spi_rxd
);
  localparam int AW = PNUM_W + PAGE_BITS;
  localparam int PSIZE = 1 << PAGE_BITS;
  localparam int TAG_W = PNUM_W + 1;
  localparam int BW = PAGE_BITS + 3;
  localparam int GW = $clog2(GUARD + 1);
  localparam logic [PNUM_W-1:0] CFG_PAGE = '1;
  localparam logic [TAG_W-1:0] NO_TAG = '1;
  localparam logic [BW-1:0] LAST_DATA = BW'(PSIZE + 3);

  typedef enum logic [2:0] {S_IDLE, S_DECIDE, S_CSL, S_SEND, S_WAIT, S_CSH, S_GAP, S_DONE} state_t;
  typedef enum logic [1:0] {K_RD, K_PG, K_ST} kind_t;

  state_t st;
  kind_t  kind, xkind, dec_kind;
  logic [PNUM_W-1:0]    op_page, xpage, dec_page;
  logic [PAGE_BITS-1:0] op_off, di;
  logic [7:0]           op_wdata, rdata;
  logic                 op_write, op_whole, op_cfg, op_flush, op_bad, merged;
  logic [TAG_W-1:0]     tag;
  logic                 dirty, wr_pend, rdy_seen, ok, cs_n_q;
  logic [BW-1:0]        bi;
  logic [GW-1:0]        gcnt;
  logic [7:0]           mem [PSIZE];
  logic [23:0]          faddr;
  logic                 hit, last, gdone;
  logic                 dec_start, dec_done, dec_ok, dec_retag, do_merge;

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_DONE) && !op_flush;
  assign flush_ack  = (st == S_DONE) && op_flush;
  assign resp_ok    = ok;
  assign resp_rdata = rdata;
  assign spi_cs_n   = cs_n_q;
  assign spi_go     = (st == S_SEND);

  assign hit   = (tag == {1'b0, op_page});
  assign di    = PAGE_BITS'(bi - BW'(4));
  assign faddr = 24'(xpage) << PAGE_BITS;
  assign last  = (kind == K_ST) ? (bi == BW'(1)) : (bi == LAST_DATA);
  assign gdone = (gcnt == GW'(GUARD - 1));

  always_comb begin
    if (kind == K_ST)      spi_txd = (bi == '0) ? OP_STAT : 8'hFF;
    else if (bi == BW'(0)) spi_txd = (kind == K_PG) ? OP_PROG : OP_READ;
    else if (bi == BW'(1)) spi_txd = faddr[23:16];
    else if (bi == BW'(2)) spi_txd = faddr[15:8];
    else if (bi == BW'(3)) spi_txd = faddr[7:0];
    else                   spi_txd = (kind == K_PG) ? mem[di] : 8'hFF;
  end

  always_comb begin
    dec_start = 1'b0;
    dec_kind  = K_PG;
    dec_page  = tag[PNUM_W-1:0];
    dec_done  = 1'b0;
    dec_ok    = 1'b1;
    dec_retag = 1'b0;
    do_merge  = 1'b0;
    if (st == S_DECIDE) begin
      if (op_bad) begin
        dec_done = 1'b1;
        dec_ok   = 1'b0;
      end else if (op_flush || merged) begin
        if (dirty && (op_flush || (op_cfg && op_write))) dec_start = 1'b1;
        else dec_done = 1'b1;
      end else if (!hit) begin
        if (dirty) dec_start = 1'b1;
        else if (op_write && op_whole && !op_cfg) dec_retag = 1'b1;
        else begin
          dec_start = 1'b1;
          dec_kind  = K_RD;
          dec_page  = op_page;
        end
      end else begin
        do_merge = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_merge && op_write) mem[op_off] <= op_wdata;
    else if (st == S_WAIT && spi_done && kind == K_RD && bi > BW'(3)) mem[di] <= spi_rxd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      kind <= K_RD;
      xkind <= K_RD;
      op_page <= '0;
      xpage <= '0;
      op_off <= '0;
      op_wdata <= '0;
      op_write <= 1'b0;
      op_whole <= 1'b0;
      op_cfg <= 1'b0;
      op_flush <= 1'b0;
      op_bad <= 1'b0;
      merged <= 1'b0;
      tag <= NO_TAG;
      dirty <= 1'b0;
      wr_pend <= 1'b0;
      rdy_seen <= 1'b0;
      ok <= 1'b0;
      rdata <= '0;
      cs_n_q <= 1'b1;
      bi <= '0;
      gcnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          merged <= 1'b0;
          if (req_valid) begin
            op_write <= req_write;
            op_whole <= req_whole;
            op_cfg   <= req_cfg;
            op_flush <= 1'b0;
            op_wdata <= req_wdata;
            op_off   <= req_addr[PAGE_BITS-1:0];
            op_page  <= req_cfg ? CFG_PAGE : req_addr[AW-1:PAGE_BITS];
            op_bad   <= req_cfg ? (req_addr[AW-1:PAGE_BITS] != '0)
                                : (req_addr[AW-1:PAGE_BITS] == CFG_PAGE);
            st <= S_DECIDE;
          end else if (flush_req) begin
            op_flush <= 1'b1;
            op_bad   <= 1'b0;
            op_write <= 1'b0;
            op_cfg   <= 1'b0;
            st <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          if (dec_done) begin
            ok <= dec_ok;
            st <= S_DONE;
          end
          if (dec_retag) tag <= {1'b0, op_page};
          if (do_merge) begin
            merged <= 1'b1;
            if (op_write) dirty <= 1'b1;
            else rdata <= mem[op_off];
          end
          if (dec_start) begin
            xkind  <= dec_kind;
            xpage  <= dec_page;
            kind   <= wr_pend ? K_ST : dec_kind;
            bi     <= '0;
            gcnt   <= '0;
            cs_n_q <= 1'b0;
            st     <= S_CSL;
          end
        end
        S_CSL: begin
          gcnt <= gcnt + 1'b1;
          if (gdone) st <= S_SEND;
        end
        S_SEND: st <= S_WAIT;
        S_WAIT: if (spi_done) begin
          if (kind == K_ST && bi == BW'(1)) rdy_seen <= spi_rxd[RDY_BIT];
          if (last) begin
            gcnt <= '0;
            st <= S_CSH;
          end else begin
            bi <= bi + 1'b1;
            st <= S_SEND;
          end
        end
        S_CSH: begin
          gcnt <= gcnt + 1'b1;
          if (gdone) begin
            cs_n_q <= 1'b1;
            gcnt <= '0;
            st <= S_GAP;
          end
        end
        S_GAP: begin
          gcnt <= gcnt + 1'b1;
          if (gdone) begin
            case (kind)
              K_ST: begin
                if (rdy_seen) begin
                  wr_pend <= 1'b0;
                  kind <= xkind;
                end
                bi <= '0;
                gcnt <= '0;
                cs_n_q <= 1'b0;
                st <= S_CSL;
              end
              K_PG: begin
                wr_pend <= 1'b1;
                dirty <= 1'b0;
                st <= S_DECIDE;
              end
              default: begin
                tag <= {1'b0, xpage};
                st <= S_DECIDE;
              end
            endcase
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cs_high_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> spi_cs_n);
  p_go_needs_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> !spi_cs_n);
  p_poll_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_go && bi == '0 && kind != K_ST) |-> !wr_pend);
  p_dirty_tagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dirty |-> (tag != NO_TAG));
  p_single_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
  p_ready_after_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || flush_ack) |=> req_ready);
  p_reject_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DECIDE && op_bad) |=> (resp_valid && !resp_ok && spi_cs_n && $stable(tag) && $stable(dirty)));
endmodule

// File: tb/spi_page_cache_tb_top.sv
`timescale 1ns/1ps
module spi_page_cache_tb_top;
  localparam int PB = 8;
  localparam int PN = 4;
  localparam int G = 2;
  localparam int PS = 1 << PB;
  localparam int FS = PS << PN;
  localparam int CFGP = (1 << PN) - 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_whole = 0, req_cfg = 0, flush_req = 0;
  logic [PN+PB-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_ok, flush_ack, spi_cs_n, spi_go;
  logic [7:0] resp_rdata, spi_txd;
  logic done_r = 0;
  logic [7:0] rxd_r = 8'hFF;

  int n_chk = 0, n_fail = 0, cyc = 0;

  spi_page_cache #(.PAGE_BITS(PB), .PNUM_W(PN), .GUARD(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_whole(req_whole), .req_cfg(req_cfg),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_ok(resp_ok), .resp_rdata(resp_rdata), .flush_req(flush_req),
    .flush_ack(flush_ack), .spi_cs_n(spi_cs_n), .spi_go(spi_go), .spi_txd(spi_txd),
    .spi_done(done_r), .spi_rxd(rxd_r));

  always #4 clk = ~clk;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // flash device and shift-engine model
  logic [7:0] fmem [FS];
  int fbusy = 0, fcnt = 0, faddr = 0, lat = 0;
  int since_fall = 100, since_done = 100, high_cyc = 100;
  int prog_cnt = 0, rd_cnt = 0, fall_cnt = 0;
  logic [7:0] fop = 8'h00;
  logic cs_prev = 1;

  always @(posedge clk) begin
    cyc++;
    if (fbusy > 0) fbusy--;
    since_fall++; since_done++; high_cyc++;
    if (done_r) since_done = 0;
    done_r <= 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) done_r <= 1'b1;
    end
    if (cs_prev && !spi_cs_n) begin
      check(high_cyc >= G, "R10 cs high gap", high_cyc, G);
      since_fall = 0; fcnt = 0; faddr = 0; fall_cnt++;
    end
    if (!cs_prev && spi_cs_n) begin
      check(since_done >= G, "R10 cs rise hold", since_done, G);
      if (fop == 8'h02) begin
        check(fcnt == 4 + PS, "R5 program length", fcnt, 4 + PS);
        prog_cnt++; fbusy = 30;
      end
      high_cyc = 0;
    end
    cs_prev = spi_cs_n;
    if (spi_go) begin
      lat = 2;
      rxd_r <= 8'hFF;
      if (fcnt == 0) begin
        check(since_fall >= G, "R10 cs setup", since_fall, G);
        fop = spi_txd;
        if (fop == 8'h03 || fop == 8'h02) begin
          check(fbusy == 0, "R6 command while busy", fbusy, 0);
          if (fop == 8'h03) rd_cnt++;
        end
      end else if (fop == 8'h05) begin
        rxd_r <= (fbusy > 0) ? 8'h00 : 8'h80;
      end else if (fcnt <= 3) begin
        faddr = (faddr << 8) | spi_txd;
        if (fcnt == 3) check(faddr[7:0] == 8'h00, "R5 low address byte", faddr & 255, 0);
      end else if (fop == 8'h03) begin
        rxd_r <= fmem[(faddr + fcnt - 4) % FS];
      end else if (fop == 8'h02) begin
        fmem[(faddr + fcnt - 4) % FS] = spi_txd;
      end
      fcnt++;
    end
  end

  always @(posedge clk) if (cyc == 150000) begin
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // reference model
  logic [7:0] emem [FS];
  logic [7:0] mbuf [PS];
  int mtag = -1;
  bit mdirty = 0;

  task automatic wb();
    for (int i = 0; i < PS; i++) emem[mtag * PS + i] = mbuf[i];
    mdirty = 0;
  endtask

  task automatic do_req(input bit wr, input bit whole, input bit cfg, input int addr,
                        input int wd, input string req);
    int p, off, eprog, eload, erd, p0, r0, f0;
    bit eok;
    p = cfg ? CFGP : (addr >> PB);
    off = addr % PS;
    eok = cfg ? ((addr >> PB) == 0) : (p != CFGP);
    eprog = 0; eload = 0; erd = 0;
    if (eok) begin
      if (mtag != p) begin
        if (mdirty) begin wb(); eprog++; end
        if (!(wr && whole && !cfg)) begin
          for (int i = 0; i < PS; i++) mbuf[i] = emem[p * PS + i];
          eload++;
        end
        mtag = p;
      end
      if (wr) begin mbuf[off] = wd[7:0]; mdirty = 1; end
      else erd = mbuf[off];
      if (cfg && wr) begin wb(); eprog++; end
    end
    p0 = prog_cnt; r0 = rd_cnt; f0 = fall_cnt;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_whole = whole; req_cfg = cfg;
    req_addr = addr[PN+PB-1:0]; req_wdata = wd[7:0];
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, {req, " R11 busy after accept"}, req_ready, 0);
    while (!resp_valid) @(negedge clk);
    check(resp_ok == eok, {req, " resp_ok"}, resp_ok, eok);
    if (eok && !wr) check(resp_rdata == erd[7:0], {req, " read data"}, resp_rdata, erd);
    check(prog_cnt - p0 == eprog, {req, " program count"}, prog_cnt - p0, eprog);
    check(rd_cnt - r0 == eload, {req, " load count"}, rd_cnt - r0, eload);
    if (eprog + eload == 0) check(fall_cnt == f0, {req, " no SPI traffic"}, fall_cnt - f0, 0);
    @(negedge clk);
    check(req_ready, {req, " R11 ready after response"}, req_ready, 1);
  endtask

  task automatic do_flush(input string req);
    int p0, f0, eprog;
    eprog = mdirty ? 1 : 0;
    if (mdirty) wb();
    p0 = prog_cnt; f0 = fall_cnt;
    @(negedge clk); flush_req = 1;
    @(negedge clk); flush_req = 0;
    while (!flush_ack) @(negedge clk);
    check(prog_cnt - p0 == eprog, {req, " flush programs"}, prog_cnt - p0, eprog);
    if (eprog == 0) check(fall_cnt == f0, {req, " clean flush quiet"}, fall_cnt - f0, 0);
  endtask

  initial begin
    for (int i = 0; i < FS; i++) begin
      fmem[i] = 8'((i * 37 + 11) ^ (i >> 8));
      emem[i] = fmem[i];
    end
    for (int i = 0; i < PS; i++) mbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(req_ready == 1, "R1 reset ready", req_ready, 1);
    check(spi_cs_n == 1, "R1 reset cs high", spi_cs_n, 1);
    check(resp_valid == 0 && flush_ack == 0, "R1 reset no pulse", resp_valid, 0);
    rst_n = 1;
    do_req(0, 0, 0, 'h005, 0, "R1 R3 first read loads");
    do_req(0, 0, 0, 'h010, 0, "R2 read hit");
    do_req(1, 0, 0, 'h020, 'hAA, "R2 write hit");
    do_req(0, 0, 0, 'h020, 0, "R2 read back");
    do_req(0, 0, 0, 'h312, 0, "R3 dirty miss");
    do_req(0, 0, 0, 'h020, 0, "R6 R3 load after program");
    do_req(1, 1, 0, 'h500, 'h55, "R4 whole write clean");
    do_req(0, 0, 0, 'h501, 0, "R4 stale byte kept");
    do_req(1, 1, 0, 'h600, 'h66, "R4 whole write dirty");
    do_flush("R7 dirty");
    do_flush("R7 clean");
    do_req(0, 0, 0, 'hF00, 0, "R9 data in config page");
    do_req(1, 0, 1, 'h100, 'h77, "R9 config offset out of page");
    do_req(0, 0, 0, 'h601, 0, "R9 state unchanged");
    do_req(1, 0, 1, 'h003, 'h3C, "R8 config write");
    do_req(0, 0, 1, 'h003, 0, "R8 config read");
    do_req(0, 0, 1, 'h004, 0, "R8 config read other");
    for (int k = 0; k < 8; k++) begin
      do_req(1, 0, 0, ((k * 5) % 15) * PS + k * 17, k * 29 + 1, "R3 mixed write");
      do_req(0, 0, 0, ((k * 3) % 15) * PS + k * 11, 0, "R3 mixed read");
    end
    do_flush("R7 final");
    repeat (40) @(negedge clk);
    begin
      int bad = 0;
      for (int i = 0; i < FS; i++) if (fmem[i] !== emem[i]) bad++;
      check(bad == 0, "R5 flash image", bad, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule